// File: doc/BRIEF.md
# Power-Fail Store and Power-Up Recall Sequencer

This block sits between two supply-monitor flags and the control of a memory that pairs a fast SRAM array with a nonvolatile shadow. One flag reports that the supply has fallen under the reset level. The other reports that the supply stands above the switch threshold. From these flags the block decides when the SRAM may be read or written, and when an external store request may go ahead. It also decides when the shadow must be copied back into the SRAM (a recall) or the SRAM copied into the shadow (a store).

Any low-power event arms a recall. The first time the supply is back above the switch level, a timed recall runs, and SRAM access stays shut until it finishes. When the supply drops through the switch level, the block tries an automatic store, but only if the SRAM has been written since the last nonvolatile cycle. It pulls the shared open-drain busy line low for a fixed pulse and watches that line. If the line really went low, it signals the store to start. If it never did, it gives the attempt up. All timings are counted in clock cycles, and every input is taken to be synchronous to `clk`.

Top module: `nv_pwr_sequencer`

## Requirements
- R1: A recall request is pending from reset, and is set again in the cycle after any cycle in which `below_reset_i` is 1. While a request is pending, `rd_grant_o`, `wr_grant_o` and `ext_store_grant_o` stay 0.
- R2: When the sequencer is idle, a recall is pending and `above_switch_i` is 1, `recall_active_o` becomes 1 in the next cycle.
- R3: While `above_switch_i` stays 1, `recall_active_o` stays high for exactly RECALL_CYC cycles. The pending request and the written-since-store flag then clear. If `above_switch_i` drops during a recall, the recall ends in the next cycle and the request stays pending.
- R4: A falling crossing means `above_switch_i` was 1 in the previous cycle and is 0 now. A falling crossing in the idle state, with the written flag set, drives `busy_pull_o` high from the next cycle for exactly PULSE_CYC cycles.
- R5: In the final pull cycle exactly one of `store_go_o` and `store_abort_o` pulses for one cycle. `store_go_o` pulses if `busy_line_i` read 0 in any pull cycle, and `store_abort_o` pulses otherwise. A go clears the written flag; an abort keeps it.
- R6: A falling crossing with the written flag clear leaves `busy_pull_o` at 0, and neither store pulse occurs.
- R7: `wr_grant_o` = `wr_req_i` and `ext_store_grant_o` = `ext_store_req_i` only while `above_switch_i` is 1, the sequencer is idle and no recall is pending. Otherwise both are 0. A granted write sets the written flag in the next cycle. A granted external store clears it, unless a write is granted in the same cycle.
- R8: `rd_grant_o` = `rd_req_i` only while the sequencer is idle and no recall is pending. Reads are therefore refused during a recall and during a store attempt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| below_reset_i | input | 1 | Supply under the reset level |
| above_switch_i | input | 1 | Supply above the switch threshold |
| busy_line_i | input | 1 | Observed level of the shared busy line (0 = low) |
| rd_req_i | input | 1 | SRAM read request |
| wr_req_i | input | 1 | SRAM write request |
| ext_store_req_i | input | 1 | Externally started store request |
| busy_pull_o | output | 1 | Pull the shared busy line low |
| recall_active_o | output | 1 | Recall in progress |
| rd_grant_o | output | 1 | Read may proceed |
| wr_grant_o | output | 1 | Write may proceed |
| ext_store_grant_o | output | 1 | External store may proceed |
| store_go_o | output | 1 | One-cycle start of the automatic store |
| store_abort_o | output | 1 | One-cycle notice of an abandoned store attempt |

## Verification
The three grants and the two store pulses are combinational on the current state and inputs. They are due in the same cycle as the stimulus. `recall_active_o` and `busy_pull_o` are registered and rise one clock after the crossing that triggers them. They fall after exactly RECALL_CYC or PULSE_CYC high cycles. A flag change caused by a grant shows only from the following cycle. The bench drives inputs just after the falling clock edge and compares every output with its behavioural model 1 ns later. The model advances on each rising edge, so every comparison lands in the cycle in which the result is due.

// File: rtl/nv_pwr_pkg.sv
package nv_pwr_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_RECALL = 2'd1,
    SEQ_PULL   = 2'd2
  } seq_state_e;
endpackage

// File: rtl/nv_pwr_edge.sv
module nv_pwr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic prev_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl_i;
  end

  assign prev_o = prev_q;
  assign fall_o = prev_q & ~lvl_i;
endmodule

// File: rtl/nv_pwr_timer.sv
module nv_pwr_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load_i | (dec_i & (cnt_q != '0));
    cnt_d  = load_i ? load_val_i : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

  AST_TIMER_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_o && !load_i) |=> zero_o); // R3
endmodule

// File: rtl/nv_pwr_flags.sv
module nv_pwr_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic set_pend_i,
  input  logic clr_pend_i,
  input  logic set_dirty_i,
  input  logic clr_dirty_i,
  output logic pend_o,
  output logic dirty_o
);
  logic pend_q, pend_d, pend_en;
  logic dirty_q, dirty_d, dirty_en;

  always_comb begin
    pend_en  = set_pend_i | clr_pend_i;
    pend_d   = set_pend_i;
    dirty_en = set_dirty_i | clr_dirty_i;
    dirty_d  = set_dirty_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b1;
      dirty_q <= 1'b0;
    end else begin
      if (pend_en)  pend_q  <= pend_d;
      if (dirty_en) dirty_q <= dirty_d;
    end
  end

  assign pend_o  = pend_q;
  assign dirty_o = dirty_q;

  AST_PEND_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    set_pend_i |=> pend_o); // R1
  AST_DIRTY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set_dirty_i |=> dirty_o); // R7
endmodule

// File: rtl/nv_pwr_sequencer.sv
module nv_pwr_sequencer
  import nv_pwr_pkg::*;
#(
  parameter int RECALL_CYC = 2000,
  parameter int PULSE_CYC  = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic below_reset_i,
  input  logic above_switch_i,
  input  logic busy_line_i,
  input  logic rd_req_i,
  input  logic wr_req_i,
  input  logic ext_store_req_i,
  output logic busy_pull_o,
  output logic recall_active_o,
  output logic rd_grant_o,
  output logic wr_grant_o,
  output logic ext_store_grant_o,
  output logic store_go_o,
  output logic store_abort_o
);
  localparam int MAXC  = (RECALL_CYC > PULSE_CYC) ? RECALL_CYC : PULSE_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] RECALL_LAST = CNT_W'(RECALL_CYC - 1);
  localparam logic [CNT_W-1:0] PULSE_LAST  = CNT_W'(PULSE_CYC - 1);

  seq_state_e       state_q, state_d;
  logic             seen_q, seen_d, seen_en;
  logic             prev_w, fall_w;
  logic             pend_w, dirty_w;
  logic             tmr_load, tmr_dec, tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  logic             recall_done;
  logic             idle_open;
  logic             line_low_any;

  nv_pwr_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (above_switch_i),
    .prev_o (prev_w),
    .fall_o (fall_w)
  );

  nv_pwr_timer #(.W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .dec_i      (tmr_dec),
    .zero_o     (tmr_zero)
  );

  nv_pwr_flags u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_pend_i  (below_reset_i),
    .clr_pend_i  (recall_done),
    .set_dirty_i (wr_grant_o),
    .clr_dirty_i (recall_done | store_go_o | ext_store_grant_o),
    .pend_o      (pend_w),
    .dirty_o     (dirty_w)
  );

  // next state
  always_comb begin
    state_d     = state_q;
    tmr_load    = 1'b0;
    tmr_val     = '0;
    tmr_dec     = 1'b0;
    recall_done = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (fall_w && dirty_w) begin
          state_d  = SEQ_PULL;
          tmr_load = 1'b1;
          tmr_val  = PULSE_LAST;
        end else if (pend_w && above_switch_i) begin
          state_d  = SEQ_RECALL;
          tmr_load = 1'b1;
          tmr_val  = RECALL_LAST;
        end
      end
      SEQ_RECALL: begin
        if (!above_switch_i) begin
          state_d = SEQ_IDLE;
        end else if (tmr_zero) begin
          state_d     = SEQ_IDLE;
          recall_done = 1'b1;
        end else begin
          tmr_dec = 1'b1;
        end
      end
      SEQ_PULL: begin
        if (tmr_zero) state_d = SEQ_IDLE;
        else          tmr_dec = 1'b1;
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  // busy-line observation during the pull pulse
  always_comb begin
    seen_en = (state_q == SEQ_PULL) | seen_q;
    seen_d  = (state_q == SEQ_PULL) & (seen_q | ~busy_line_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      seen_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (seen_en) seen_q <= seen_d;
    end
  end

  always_comb begin
    idle_open         = (state_q == SEQ_IDLE) & ~pend_w;
    line_low_any      = seen_q | ~busy_line_i;
    busy_pull_o       = (state_q == SEQ_PULL);
    recall_active_o   = (state_q == SEQ_RECALL);
    rd_grant_o        = rd_req_i & idle_open;
    wr_grant_o        = wr_req_i & idle_open & above_switch_i;
    ext_store_grant_o = ext_store_req_i & idle_open & above_switch_i;
    store_go_o        = busy_pull_o & tmr_zero & line_low_any;
    store_abort_o     = busy_pull_o & tmr_zero & ~line_low_any;
  end

  AST_RECALL_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(recall_active_o) |-> $past(pend_w)); // R2
  AST_RECALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    recall_done |=> (!dirty_w && (!pend_w || $past(below_reset_i)))); // R3
  AST_PULL_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_pull_o) |-> $past(prev_w && !above_switch_i)); // R4
  AST_GO_ABORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(store_go_o && store_abort_o)); // R5
  AST_GO_CLEARS_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    store_go_o |=> !dirty_w); // R5
  AST_PULL_NEEDS_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_pull_o) |-> $past(dirty_w)); // R6
  AST_NO_ACCESS_RECALL: assert property (@(posedge clk) disable iff (!rst_n)
    recall_active_o |-> (!rd_grant_o && !wr_grant_o)); // R8
endmodule

// File: tb/tb_nv_pwr_sequencer.sv
module tb_nv_pwr_sequencer;
  localparam int RC = 20;
  localparam int PC = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic below, above, rd, wr, ext, stuck;
  logic busy_line;
  logic pull, rec, rdg, wrg, extg, go, abrt;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  assign busy_line = stuck | ~pull;

  nv_pwr_sequencer #(.RECALL_CYC(RC), .PULSE_CYC(PC)) dut (
    .clk(clk), .rst_n(rst_n),
    .below_reset_i(below), .above_switch_i(above), .busy_line_i(busy_line),
    .rd_req_i(rd), .wr_req_i(wr), .ext_store_req_i(ext),
    .busy_pull_o(pull), .recall_active_o(rec), .rd_grant_o(rdg),
    .wr_grant_o(wrg), .ext_store_grant_o(extg),
    .store_go_o(go), .store_abort_o(abrt)
  );

  // behavioural reference: st 0 idle, 1 recall, 2 pull
  int m_st, m_cnt;
  bit m_pend, m_dirty, m_aq, m_seen;

  function automatic bit m_open();
    return (m_st == 0) && !m_pend;
  endfunction
  function automatic bit m_line();
    return stuck || (m_st != 2);
  endfunction
  function automatic bit m_go();
    return (m_st == 2) && (m_cnt == 0) && (m_seen || !m_line());
  endfunction
  function automatic bit m_abort();
    return (m_st == 2) && (m_cnt == 0) && !(m_seen || !m_line());
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_pend = 1; m_dirty = 0; m_aq = 0; m_seen = 0;
    end else begin
      int nst, ncnt;
      bit npend, ndirty, nseen, wg, eg;
      nst = m_st; ncnt = m_cnt; npend = m_pend; ndirty = m_dirty;
      wg = wr && above && m_open();
      eg = ext && above && m_open();
      nseen = (m_st == 2) ? (m_seen || !m_line()) : 1'b0;
      if (m_st == 0) begin
        if (m_aq && !above && m_dirty) begin nst = 2; ncnt = PC - 1; end
        else if (m_pend && above)      begin nst = 1; ncnt = RC - 1; end
      end else if (m_st == 1) begin
        if (!above) nst = 0;
        else if (m_cnt == 0) begin nst = 0; npend = 0; ndirty = 0; end
        else ncnt = m_cnt - 1;
      end else begin
        if (m_cnt == 0) begin nst = 0; if (m_go()) ndirty = 0; end
        else ncnt = m_cnt - 1;
      end
      if (below) npend = 1;
      if (wg) ndirty = 1;
      else if (eg) ndirty = 0;
      m_st = nst; m_cnt = ncnt; m_pend = npend; m_dirty = ndirty;
      m_seen = nseen; m_aq = above;
    end
  end

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R4", "busy_pull", pull, m_st == 2);
    chk("R3", "recall_active", rec, m_st == 1);
    chk("R8", "rd_grant", rdg, rd && m_open());
    chk("R7", "wr_grant", wrg, wr && above && m_open());
    chk("R7", "ext_store_grant", extg, ext && above && m_open());
    chk("R5", "store_go", go, m_go());
    chk("R5", "store_abort", abrt, m_abort());
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      #1 compare_all();
      @(negedge clk);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    report();
  end

  initial begin
    rst_n = 0; below = 1; above = 0; rd = 1; wr = 1; ext = 1; stuck = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1", "reset rd_grant", rdg, 1'b0);
    chk("R1", "reset busy_pull", pull, 1'b0);
    chk("R1", "reset recall_active", rec, 1'b0);
    step(3);
    // supply returns: recall
    below = 0; above = 1; wr = 0; ext = 0;
    step(1);
    #1 chk("R2", "recall starts", rec, 1'b1);
    chk("R8", "read blocked in recall", rdg, 1'b0);
    step(RC - 1);
    #1 chk("R3", "recall still on at last cycle", rec, 1'b1);
    step(1);
    #1 chk("R3", "recall over after RC cycles", rec, 1'b0);
    chk("R8", "read open after recall", rdg, 1'b1);
    // writes make it dirty, then power fails with a working line
    wr = 1; step(2); wr = 0; rd = 0;
    above = 0;
    step(1);
    #1 chk("R4", "pull begins", pull, 1'b1);
    chk("R7", "write blocked below switch", wrg, 1'b0);
    wr = 1; ext = 1;
    step(PC - 1);
    #1 chk("R5", "store go on working line", go, 1'b1);
    step(1);
    wr = 0; ext = 0;
    // back up (no pending recall), now clean: a fall skips the store
    above = 1; step(2);
    #1 chk("R3", "no recall without request", rec, 1'b0);
    above = 0; step(2);
    #1 chk("R6", "no pull when clean", pull, 1'b0);
    step(PC);
    // dirty again, stuck line -> abort
    above = 1; step(1); wr = 1; step(1); wr = 0;
    stuck = 1; above = 0;
    step(PC);
    #1 chk("R5", "abort on stuck line", abrt, 1'b1);
    step(1);
    stuck = 0;
    // external store clears dirty
    above = 1; step(1); ext = 1; step(1); ext = 0;
    above = 0; step(2);
    #1 chk("R7", "external store cleaned, no pull", pull, 1'b0);
    // brown-out to reset level, recall interrupted then completed
    below = 1; step(2); below = 0;
    above = 1; step(5); above = 0; step(1);
    #1 chk("R3", "recall aborted on drop", rec, 1'b0);
    rd = 1;
    #1 chk("R1", "still pending after aborted recall", rdg, 1'b0);
    above = 1; step(RC + 2);
    #1 chk("R8", "read open after full recall", rdg, 1'b1);
    // random phase
    for (int k = 0; k < 1500; k++) begin
      if ($urandom_range(0, 29) == 0) above = ~above;
      below = ($urandom_range(0, 99) == 0) && !above;
      rd = $urandom_range(0, 1);
      wr = $urandom_range(0, 2) == 0;
      ext = $urandom_range(0, 9) == 0;
      stuck = $urandom_range(0, 3) == 0 ? ~stuck : stuck;
      step(1);
    end
    report();
  end
endmodule